// File: doc/BRIEF.md
# Two-Way Write-Back Cache Controller

This block is a two-way set-associative data cache for a 16-bit byte address space. It sits between a CPU port and a block-oriented memory port. It holds 64 sets of two 16-byte lines, which is 128 frames of four 32-bit words. The CPU issues byte or word reads and writes. The cache keeps written data in the line and marks that line dirty. Memory is updated only when a dirty line is evicted. A write that misses first brings the block into the cache and then completes as a hit.

A request is held on the CPU port until `cpu_ready` pulses for one cycle. The controller is a five-state machine:

- **IDLE** registers a request and moves to **COMPARE**.
- **COMPARE** checks both tags of the indexed set in parallel. On a hit it serves the access and returns to **IDLE**. On a miss it chooses a victim and goes to **WRITEBACK** if the victim is dirty, or to **REFILL** if it is clean.
- **WRITEBACK** sends the victim line to memory and leaves for **REFILL** on `mem_ack`.
- **REFILL** fetches the missing block and leaves for **DONE** on `mem_ack`.
- **DONE** replays the access on the refilled line and returns to **IDLE**.

The victim policy is chosen by a parameter. It is either one least-recently-used bit per set, or the low bit of a free-running 8-bit LFSR. In both modes an invalid way is always filled before a valid way is evicted.

Top module: `sa_wb_cache`

## Requirements
- R1: An address splits into tag = addr[15:10], set = addr[9:4], word = addr[3:2] and byte = addr[1:0]. Blocks with the same set field and different tags compete for the two ways of that set.
- R2: `cpu_ready` is low after reset and while no access is being served. A hit raises `cpu_ready` for exactly one cycle, at the first falling edge after the rising edge that registered the request. `cpu_rdata` is valid in that cycle.
- R3: `cpu_word`=1 selects a 32-bit access to the word at addr[3:2]. `cpu_word`=0 selects a byte access to byte lane addr[1:0] of that word. A byte write changes only that byte. A byte read returns the byte in bits [7:0] with zeros above.
- R4: A write hit updates only the cache line, marks the line dirty and issues no memory transaction.
- R5: When the victim is dirty, its whole line is written to memory first. The write has `mem_we`=1 and `mem_addr` = {victim tag, set}, and carries the latest data. The refill comes after it.
- R6: A clean victim is dropped without any memory write. The miss issues only the refill read.
- R7: A write miss first refills the block and then performs the write. The line is then resident and dirty, and later reads of it hit. Memory receives the data only on eviction.
- R8: Reset clears every valid and dirty bit, so the first access to any block misses. On a miss, an invalid way of the set is filled before any valid way is evicted.
- R9: In LRU mode, each hit or refill marks the other way of the set as the next victim. A miss with both ways valid evicts the way used less recently.
- R10: In random mode, with both ways valid, bit 0 of a free-running 8-bit LFSR picks the victim. The LFSR is seeded to 1 and never reaches zero. Over many sets both ways get chosen.
- R11: `mem_req` is held, with `mem_addr` and `mem_we` unchanged, until `mem_ack`. Refill data is taken from `mem_rdata` in the `mem_ack` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_word | input | 1 | 1 = 32-bit word access, 0 = byte access |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 32 | Write data (byte writes use bits [7:0]) |
| cpu_rdata | output | 32 | Read data, valid while cpu_ready is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Block transfer request |
| mem_we | output | 1 | 1 = write back a line, 0 = refill read |
| mem_addr | output | 12 | Block address {tag, set} |
| mem_wdata | output | 128 | Line sent to memory on write-back |
| mem_rdata | input | 128 | Line returned on refill |
| mem_ack | input | 1 | One-cycle transfer completion |

## Verification
The bench builds two copies at the default geometry of 64 sets, 16-byte lines and 6-bit tags. The first copy uses LRU replacement and the second uses LFSR replacement. With six-bit tags, three tags per set are enough to force every replacement case. Every one of the 64 sets is walked through a clean miss, a write miss into the free way, byte merging, a dirty eviction and a clean eviction. A behavioural memory with a two-cycle acknowledge holds a computed pattern, and a golden array predicts every read and every written-back line. The random copy is checked for victim choices that cover both ways across 32 sets.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COMPARE,
        ST_WRITEBACK,
        ST_REFILL,
        ST_DONE
    } cache_state_e;

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
    parameter int SETS  = 64,
    parameter int SET_W = 6,
    parameter int TAG_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SET_W-1:0]      set_i,
    input  logic                  fill_en,
    input  logic                  fill_way,
    input  logic [TAG_W-1:0]      fill_tag,
    input  logic                  dirty_en,
    input  logic                  dirty_way,
    output logic [1:0]            valid_o,
    output logic [1:0]            dirty_o,
    output logic [1:0][TAG_W-1:0] tag_o
);

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [SETS-1:0]  vld_q;
        logic [SETS-1:0]  drt_q;
        logic [TAG_W-1:0] tag_q [SETS];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= '0;
                drt_q <= '0;
            end else if (fill_en && (fill_way == w[0])) begin
                vld_q[set_i] <= 1'b1;
                drt_q[set_i] <= 1'b0;
            end else if (dirty_en && (dirty_way == w[0])) begin
                drt_q[set_i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_en && (fill_way == w[0])) begin
                tag_q[set_i] <= fill_tag;
            end
        end

        assign valid_o[w] = vld_q[set_i];
        assign dirty_o[w] = drt_q[set_i];
        assign tag_o[w]   = tag_q[set_i];
    end

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
    parameter int SETS   = 64,
    parameter int SET_W  = 6,
    parameter int LINE_W = 128
) (
    input  logic                   clk,
    input  logic [SET_W-1:0]       set_i,
    input  logic                   wr_en,
    input  logic                   wr_way,
    input  logic [LINE_W/8-1:0]    wr_be,
    input  logic [LINE_W-1:0]      wr_line,
    output logic [1:0][LINE_W-1:0] line_o
);

    localparam int LINE_B = LINE_W / 8;

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [LINE_W-1:0] mem_q [SETS];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == w[0])) begin
                for (int b = 0; b < LINE_B; b++) begin
                    if (wr_be[b]) begin
                        mem_q[set_i][b*8 +: 8] <= wr_line[b*8 +: 8];
                    end
                end
            end
        end

        assign line_o[w] = mem_q[set_i];
    end

endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel #(
    parameter int SETS          = 64,
    parameter int SET_W         = 6,
    parameter bit RANDOM_VICTIM = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_i,
    input  logic [1:0]       valid_i,
    input  logic             touch_en,
    input  logic             touch_way,
    output logic             victim_o
);

    logic pick;

    if (RANDOM_VICTIM) begin : g_rnd
        logic [7:0] lfsr_q;
        wire unused_touch = ^{touch_en, touch_way, set_i};

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lfsr_q <= 8'h01;
            end else begin
                lfsr_q <= {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
            end
        end
        assign pick = lfsr_q[0];
    end else begin : g_lru
        logic [SETS-1:0] lru_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lru_q <= '0;
            end else if (touch_en) begin
                lru_q[set_i] <= ~touch_way;
            end
        end
        assign pick = lru_q[set_i];
    end

    always_comb begin
        if (!valid_i[0]) begin
            victim_o = 1'b0;
        end else if (!valid_i[1]) begin
            victim_o = 1'b1;
        end else begin
            victim_o = pick;
        end
    end

endmodule

// File: rtl/sa_wb_cache.sv
module sa_wb_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int SETS          = 64,
    parameter int WORDS         = 4,
    parameter int WORD_W        = 32,
    parameter bit RANDOM_VICTIM = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cpu_req,
    input  logic                          cpu_we,
    input  logic                          cpu_word,
    input  logic [ADDR_W-1:0]             cpu_addr,
    input  logic [WORD_W-1:0]             cpu_wdata,
    output logic [WORD_W-1:0]             cpu_rdata,
    output logic                          cpu_ready,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [ADDR_W-$clog2(WORDS*WORD_W/8)-1:0] mem_addr,
    output logic [WORDS*WORD_W-1:0]       mem_wdata,
    input  logic [WORDS*WORD_W-1:0]       mem_rdata,
    input  logic                          mem_ack
);

    localparam int WORD_B = WORD_W / 8;
    localparam int LINE_W = WORDS * WORD_W;
    localparam int LINE_B = LINE_W / 8;
    localparam int OFF_W  = $clog2(LINE_B);
    localparam int BSEL_W = $clog2(WORD_B);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
    localparam int BLK_W  = ADDR_W - OFF_W;

    cache_state_e state_q, state_d;

    logic              we_q, word_q, victim_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;

    logic [TAG_W-1:0]  tag_f;
    logic [SET_W-1:0]  set_f;
    logic [WSEL_W-1:0] wsel_f;
    logic [BSEL_W-1:0] bsel_f;

    assign tag_f  = addr_q[ADDR_W-1 -: TAG_W];
    assign set_f  = addr_q[OFF_W +: SET_W];
    assign wsel_f = addr_q[BSEL_W +: WSEL_W];
    assign bsel_f = addr_q[BSEL_W-1:0];

    logic [1:0]             way_valid, way_dirty, hit_vec;
    logic [1:0][TAG_W-1:0]  way_tag;
    logic [1:0][LINE_W-1:0] way_line;
    logic                   cmp_hit, hit_way, victim_pick, vic_dirty;
    logic                   do_access, acc_way, fill_en;
    logic                   dwr_en, dwr_way;
    logic [LINE_B-1:0]      dwr_be, acc_be;
    logic [LINE_W-1:0]      dwr_line, acc_line;
    logic [WORD_W-1:0]      sel_word;

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == tag_f);
    end

    assign cmp_hit   = |hit_vec;
    assign hit_way   = hit_vec[1];
    assign vic_dirty = way_valid[victim_pick] && way_dirty[victim_pick];
    assign do_access = ((state_q == ST_COMPARE) && cmp_hit) || (state_q == ST_DONE);
    assign acc_way   = (state_q == ST_DONE) ? victim_q : hit_way;
    assign fill_en   = (state_q == ST_REFILL) && mem_ack;

    cache_tag_store #(
        .SETS (SETS),
        .SET_W(SET_W),
        .TAG_W(TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_f),
        .fill_en  (fill_en),
        .fill_way (victim_q),
        .fill_tag (tag_f),
        .dirty_en (do_access && we_q),
        .dirty_way(acc_way),
        .valid_o  (way_valid),
        .dirty_o  (way_dirty),
        .tag_o    (way_tag)
    );

    cache_victim_sel #(
        .SETS         (SETS),
        .SET_W        (SET_W),
        .RANDOM_VICTIM(RANDOM_VICTIM)
    ) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_f),
        .valid_i  (way_valid),
        .touch_en (do_access || fill_en),
        .touch_way(fill_en ? victim_q : acc_way),
        .victim_o (victim_pick)
    );

    always_comb begin
        acc_be = '0;
        if (word_q) begin
            acc_be[wsel_f*WORD_B +: WORD_B] = {WORD_B{1'b1}};
            acc_line = {WORDS{wdata_q}};
        end else begin
            acc_be[{wsel_f, bsel_f}] = 1'b1;
            acc_line = {LINE_B{wdata_q[7:0]}};
        end
    end

    always_comb begin
        if (fill_en) begin
            dwr_en   = 1'b1;
            dwr_way  = victim_q;
            dwr_be   = {LINE_B{1'b1}};
            dwr_line = mem_rdata;
        end else begin
            dwr_en   = do_access && we_q;
            dwr_way  = acc_way;
            dwr_be   = acc_be;
            dwr_line = acc_line;
        end
    end

    cache_data_store #(
        .SETS  (SETS),
        .SET_W (SET_W),
        .LINE_W(LINE_W)
    ) u_data (
        .clk    (clk),
        .set_i  (set_f),
        .wr_en  (dwr_en),
        .wr_way (dwr_way),
        .wr_be  (dwr_be),
        .wr_line(dwr_line),
        .line_o (way_line)
    );

    assign sel_word = way_line[acc_way][wsel_f*WORD_W +: WORD_W];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request and victim capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q     <= 1'b0;
            word_q   <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            victim_q <= 1'b0;
        end else begin
            if ((state_q == ST_IDLE) && cpu_req) begin
                we_q    <= cpu_we;
                word_q  <= cpu_word;
                addr_q  <= cpu_addr;
                wdata_q <= cpu_wdata;
            end
            if (state_q == ST_COMPARE) begin
                victim_q <= victim_pick;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (cpu_req) state_d = ST_COMPARE;
            ST_COMPARE: begin
                if (cmp_hit)        state_d = ST_IDLE;
                else if (vic_dirty) state_d = ST_WRITEBACK;
                else                state_d = ST_REFILL;
            end
            ST_WRITEBACK: if (mem_ack) state_d = ST_REFILL;
            ST_REFILL:    if (mem_ack) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cpu_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {tag_f, set_f};
        mem_wdata = way_line[victim_q];
        cpu_rdata = word_q ? sel_word : {{(WORD_W-8){1'b0}}, sel_word[bsel_f*8 +: 8]};
        unique case (state_q)
            ST_IDLE:      ;
            ST_COMPARE:   cpu_ready = cmp_hit;
            ST_WRITEBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {way_tag[victim_q], set_f};
            end
            ST_REFILL:    mem_req = 1'b1;
            ST_DONE:      cpu_ready = 1'b1;
            default:      ;
        endcase
    end

endmodule

// File: rtl/cache_checker.sv
module cache_checker
    import cache_pkg::*;
#(
    parameter int BLK_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_ready,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_ack,
    input logic [BLK_W-1:0] mem_addr,
    input cache_state_e     state,
    input logic             cmp_hit,
    input logic             vic_dirty
);

    // R2: completion is a single-cycle pulse
    p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R2: no completion while a memory transfer is pending
    p_ready_no_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req);

    // R11: request, address and direction held until acknowledge
    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5: a finished write-back is followed by the refill
    p_wb_then_refill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    // R6: clean victim goes straight to refill, never to a memory write
    p_clean_no_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMPARE && !cmp_hit && !vic_dirty) |=> (mem_req && !mem_we));

    // R7: the replayed access only follows a completed refill
    p_replay_after_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |-> $past(mem_ack && mem_req && !mem_we));

endmodule

bind sa_wb_cache cache_checker #(.BLK_W(BLK_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_ready(cpu_ready),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .state    (state_q),
    .cmp_hit  (cmp_hit),
    .vic_dirty(vic_dirty)
);

// File: tb/sa_wb_cache_tb.sv
module cache_mem_model #(
    parameter int BLK_W  = 12,
    parameter int LINE_W = 128,
    parameter int LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [BLK_W-1:0]  addr,
    input  logic [LINE_W-1:0] wdata,
    output logic [LINE_W-1:0] rdata,
    output logic              ack,
    output int                wr_cnt,
    output int                rd_cnt,
    output logic [BLK_W-1:0]  last_addr,
    output logic [LINE_W-1:0] last_data
);

    logic [LINE_W-1:0] store [1 << BLK_W];
    int                cnt;

    function automatic logic [127:0] pattern(input int blk);
        logic [127:0] l;
        for (int w = 0; w < 4; w++) l[w*32 +: 32] = {8'h5A, 4'(w), 8'h00, 12'(blk)};
        return l;
    endfunction

    initial begin
        for (int b = 0; b < (1 << BLK_W); b++) store[b] = pattern(b);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0; cnt <= 0; wr_cnt <= 0; rd_cnt <= 0;
            rdata <= '0; last_addr <= '0; last_data <= '0;
        end else begin
            ack <= 1'b0;
            if (req && !ack) begin
                if (cnt == LAT) begin
                    ack <= 1'b1;
                    cnt <= 0;
                    if (we) begin
                        store[addr] <= wdata;
                        wr_cnt      <= wr_cnt + 1;
                        last_addr   <= addr;
                        last_data   <= wdata;
                    end else begin
                        rdata  <= store[addr];
                        rd_cnt <= rd_cnt + 1;
                    end
                end else begin
                    cnt <= cnt + 1;
                end
            end
        end
    end

endmodule

module sa_wb_cache_tb;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic         req   [2];
    logic         we    [2];
    logic         word  [2];
    logic [15:0]  addr  [2];
    logic [31:0]  wdata [2];
    logic [31:0]  rdata [2];
    logic         ready [2];
    logic         mreq  [2];
    logic         mwe   [2];
    logic [11:0]  maddr [2];
    logic [127:0] mwdat [2];
    logic [127:0] mrdat [2];
    logic         mack  [2];
    int           wrc   [2];
    int           rdc   [2];
    logic [11:0]  laddr [2];
    logic [127:0] ldata [2];

    logic [127:0] gm [2][4096];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    sa_wb_cache #(.RANDOM_VICTIM(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(req[0]), .cpu_we(we[0]), .cpu_word(word[0]),
        .cpu_addr(addr[0]), .cpu_wdata(wdata[0]), .cpu_rdata(rdata[0]), .cpu_ready(ready[0]),
        .mem_req(mreq[0]), .mem_we(mwe[0]), .mem_addr(maddr[0]), .mem_wdata(mwdat[0]),
        .mem_rdata(mrdat[0]), .mem_ack(mack[0]));

    sa_wb_cache #(.RANDOM_VICTIM(1'b1)) u_dut_rnd (
        .clk(clk), .rst_n(rst_n), .cpu_req(req[1]), .cpu_we(we[1]), .cpu_word(word[1]),
        .cpu_addr(addr[1]), .cpu_wdata(wdata[1]), .cpu_rdata(rdata[1]), .cpu_ready(ready[1]),
        .mem_req(mreq[1]), .mem_we(mwe[1]), .mem_addr(maddr[1]), .mem_wdata(mwdat[1]),
        .mem_rdata(mrdat[1]), .mem_ack(mack[1]));

    for (genvar k = 0; k < 2; k++) begin : g_mem
        cache_mem_model u_mem (
            .clk(clk), .rst_n(rst_n), .req(mreq[k]), .we(mwe[k]), .addr(maddr[k]),
            .wdata(mwdat[k]), .rdata(mrdat[k]), .ack(mack[k]), .wr_cnt(wrc[k]),
            .rd_cnt(rdc[k]), .last_addr(laddr[k]), .last_data(ldata[k]));
    end

    function automatic logic [127:0] pat(input int blk);
        logic [127:0] l;
        for (int w = 0; w < 4; w++) l[w*32 +: 32] = {8'h5A, 4'(w), 8'h00, 12'(blk)};
        return l;
    endfunction

    function automatic logic [15:0] mk(input int tag, input int set, input int off);
        return {6'(tag), 6'(set), 4'(off)};
    endfunction

    task automatic check(input bit ok, input string rq, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // One CPU access; returns read data and the number of falling edges to ready.
    task automatic access(input int k, input logic w, input logic isw, input logic [15:0] a,
                          input logic [31:0] d, output logic [31:0] q, output int cyc,
                          output logic [31:0] expq);
        logic [127:0] l;
        l = gm[k][a[15:4]];
        expq = isw ? l[a[3:2]*32 +: 32] : {24'h0, l[a[3:0]*8 +: 8]};
        @(negedge clk);
        req[k] = 1'b1; we[k] = w; word[k] = isw; addr[k] = a; wdata[k] = d;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!ready[k] && cyc < 500);
        q = rdata[k];
        req[k] = 1'b0;
        if (w) begin
            if (isw) gm[k][a[15:4]][a[3:2]*32 +: 32] = d;
            else     gm[k][a[15:4]][a[3:0]*8 +: 8] = d[7:0];
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] q, e;
        int cyc, w0, r0, hits1;
        for (int k = 0; k < 2; k++) begin
            req[k] = 0; we[k] = 0; word[k] = 0; addr[k] = '0; wdata[k] = '0;
            for (int b = 0; b < 4096; b++) gm[k][b] = pat(b);
        end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: idle after reset
        check(!ready[0] && !mreq[0], "R2 reset idle", {ready[0], mreq[0]}, 0);

        // Sweep every set of the LRU copy
        for (int s = 0; s < 64; s++) begin
            // R8/R1: first read misses, clean refill, no write (R6), refill data (R11)
            w0 = wrc[0]; r0 = rdc[0];
            access(0, 0, 1, mk(1, s, 4*(s%4)), 0, q, cyc, e);
            check(cyc > 1 && rdc[0] == r0 + 1, "R8 cold miss", cyc, 2);
            check(wrc[0] == w0, "R6 clean refill no write", wrc[0], w0);
            check(q == e, "R11 refill data", q, e);
            // R2: hit in one cycle
            access(0, 0, 1, mk(1, s, 0), 0, q, cyc, e);
            check(cyc == 1 && q == e, "R2 hit latency/data", {cyc, q}, {32'd1, e});
            // R7: write miss allocates into the free way (R8)
            r0 = rdc[0];
            access(0, 1, 1, mk(2, s, 8), 32'hC0DE_0000 + s, q, cyc, e);
            check(cyc > 1 && rdc[0] == r0 + 1 && wrc[0] == w0, "R7 write miss allocate",
                  rdc[0], r0 + 1);
            access(0, 0, 1, mk(1, s, 4), 0, q, cyc, e);
            check(cyc == 1, "R8 invalid way filled first", cyc, 1);
            access(0, 0, 1, mk(2, s, 8), 0, q, cyc, e);
            check(cyc == 1 && q == 32'hC0DE_0000 + s, "R7 allocated line hit", q,
                  32'hC0DE_0000 + s);
            // R3/R4: byte write hit merges one lane without memory traffic
            r0 = rdc[0];
            access(0, 1, 0, mk(1, s, 4 + (s % 4)), 32'hFFFF_FF00 | s, q, cyc, e);
            check(cyc == 1 && rdc[0] == r0 && wrc[0] == w0, "R4 write hit no memory",
                  {rdc[0], wrc[0]}, {r0, w0});
            access(0, 0, 1, mk(1, s, 4), 0, q, cyc, e);
            check(q == e, "R3 byte merge in word", q, e);
            access(0, 0, 0, mk(1, s, 4 + (s % 4)), 0, q, cyc, e);
            check(q == {24'h0, 8'(s)}, "R3 byte read zero-extended", q, {24'h0, 8'(s)});
            // R9/R5: tag 3 evicts dirty tag 2 (least recently used)
            access(0, 0, 1, mk(3, s, 12), 0, q, cyc, e);
            check(wrc[0] == w0 + 1 && laddr[0] == {6'd2, 6'(s)}, "R5 dirty write-back addr",
                  laddr[0], {6'd2, 6'(s)});
            check(ldata[0] == gm[0][{6'd2, 6'(s)}], "R5 write-back data", ldata[0],
                  gm[0][{6'd2, 6'(s)}]);
            check(q == e, "R9 refill after eviction data", q, e);
            access(0, 0, 1, mk(1, s, 0), 0, q, cyc, e);
            check(cyc == 1, "R9 recently used line kept", cyc, 1);
            // R6: tag 2 returns, evicting clean tag 3 without write; data from memory
            access(0, 0, 1, mk(2, s, 8), 0, q, cyc, e);
            check(cyc > 1 && wrc[0] == w0 + 1, "R6 clean victim no write", wrc[0], w0 + 1);
            check(q == 32'hC0DE_0000 + s, "R5 round trip through memory", q,
                  32'hC0DE_0000 + s);
        end
        // R1: distinct tags in different sets did not disturb each other
        access(0, 0, 1, mk(1, 5, 4), 0, q, cyc, e);
        check(cyc == 1 && q == e, "R1 set isolation", q, e);

        // Random-victim copy
        hits1 = 0;
        for (int s = 0; s < 32; s++) begin
            access(1, 0, 1, mk(1, s, 0), 0, q, cyc, e);
            access(1, 0, 1, mk(2, s, 0), 0, q, cyc, e);
            access(1, 0, 1, mk(1, s, 0), 0, q, cyc, e);
            check(cyc == 1, "R8 random mode fills invalid way", cyc, 1);
            access(1, 0, 1, mk(3, s, 4), 0, q, cyc, e);
            check(q == e, "R10 random refill data", q, e);
            access(1, 0, 1, mk(3, s, 4), 0, q, cyc, e);
            check(cyc == 1, "R10 new line resident", cyc, 1);
            access(1, 0, 1, mk(1, s, 0), 0, q, cyc, e);
            if (cyc == 1) hits1++;
        end
        check(hits1 > 0 && hits1 < 32, "R10 both ways chosen", hits1, 16);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule